// File: doc/BRIEF.md
# MSB-First Asynchronous Serial Link

This block carries 8-bit character codes over a single asynchronous wire in each direction. The transmit half frames a byte with one low start bit and one high stop bit. It shifts the data out at a fixed bit period with the most-significant bit first, which is the reverse of the common serial order. The line rests high between frames. A send strobe starts a frame, and a busy flag covers the whole frame.

The receive half passes the incoming line through a two-flop synchronizer. It confirms a start bit at half a bit period and then samples each data bit and the stop bit at mid-bit. A good stop bit yields a one-cycle valid pulse with the byte. A low stop bit yields a one-cycle framing-error pulse instead, and the output byte is left as it was. One parameter, the clock cycles per bit, sets the bit period for both halves.

Top module: `msb_serial_link`

## Requirements
- R1: After reset `tx_line` is 1, `tx_busy` is 0, and `rx_valid` and `rx_frame_err` are 0.
- R2: After a `tx_send` strobe is taken while idle, `tx_line` from the next clock edge carries ten bits of `CLKS_PER_BIT` cycles each: a 0, then `tx_data` bit 7 down to bit 0, then a 1. For example, 0x41 is sent as 0, 0,1,0,0,0,0,0,1, 1.
- R3: `tx_busy` rises on the edge that takes the strobe and stays 1 to the end of the stop bit. It is 0 one bit period after the stop bit begins, and `tx_line` is then 1.
- R4: A `tx_send` strobe while `tx_busy` is 1 is ignored: the frame in progress goes out unchanged and no further frame follows it.
- R5: A received frame with a high stop bit gives a one-cycle `rx_valid` pulse. During that pulse `rx_data` holds the eight data bits, the first bit received in bit 7.
- R6: A low pulse on `rx_line` shorter than half a bit period is not taken as a start bit. No `rx_valid` and no `rx_frame_err` follow it.
- R7: A frame whose stop bit samples 0 gives a one-cycle `rx_frame_err` pulse and no `rx_valid`, and `rx_data` keeps the last good byte.
- R8: After a framing error the receiver waits for the line to return to 1 before it looks for a new start bit. A line held low produces only one error, and a good frame after the line returns high is received.
- R9: Frames sent back to back from the transmitter into the receiver are all received in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to send, taken with the strobe |
| tx_send | input | 1 | Send strobe |
| tx_busy | output | 1 | Frame in progress on the transmit line |
| tx_line | output | 1 | Serial output, high when idle |
| rx_line | input | 1 | Serial input, asynchronous to clk |
| rx_data | output | 8 | Last byte received with a good stop bit |
| rx_valid | output | 1 | One-cycle pulse for a new byte |
| rx_frame_err | output | 1 | One-cycle pulse for a low stop bit |

## Verification
The hardest case to reach is a low stop bit followed by a line that stays low, because the block's own transmitter can never produce it. The bench therefore stops looping the transmitter back and drives the receive line itself. It sends a frame with a 0 stop bit, holds the line low for several more bit periods, and then releases it. It expects exactly one error pulse and no phantom byte, and after that it expects a clean frame to be received. A start glitch shorter than half a bit is driven in the same way.

// File: rtl/msb_serial_link.sv
module msb_serial_link #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_send,
  output logic       tx_busy,
  output logic       tx_line,
  input  logic       rx_line,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_frame_err
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID = CW'(HALF - 1);

  logic [9:0]    tx_frame;
  logic [CW-1:0] tx_cnt;
  logic [3:0]    tx_nbit;

  assign tx_line = tx_busy ? tx_frame[9] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      tx_frame <= '1;
      tx_cnt   <= '0;
      tx_nbit  <= '0;
    end else if (!tx_busy) begin
      if (tx_send) begin
        tx_frame <= {1'b0, tx_data, 1'b1};
        tx_busy  <= 1'b1;
        tx_cnt   <= '0;
        tx_nbit  <= '0;
      end
    end else if (tx_cnt == LAST) begin
      tx_cnt <= '0;
      if (tx_nbit == 4'd9) begin
        tx_busy <= 1'b0;
      end else begin
        tx_nbit  <= tx_nbit + 4'd1;
        tx_frame <= {tx_frame[8:0], 1'b1};
      end
    end else begin
      tx_cnt <= tx_cnt + 1'b1;
    end
  end

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_t;
  rx_state_t     rx_state;
  logic [1:0]    rx_sync;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_idx;
  logic [7:0]    rx_shift;
  logic          rx_s;

  assign rx_s = rx_sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync      <= 2'b11;
      rx_state     <= RX_IDLE;
      rx_cnt       <= '0;
      rx_idx       <= '0;
      rx_shift     <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_sync      <= {rx_sync[0], rx_line};
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      case (rx_state)
        RX_IDLE: begin
          rx_cnt <= '0;
          if (!rx_s) rx_state <= RX_START;
        end
        RX_START: begin
          if (rx_cnt == MID) begin
            rx_cnt   <= '0;
            rx_idx   <= '0;
            rx_state <= rx_s ? RX_IDLE : RX_DATA;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        RX_DATA: begin
          if (rx_cnt == LAST) begin
            rx_cnt   <= '0;
            rx_shift <= {rx_shift[6:0], rx_s};
            if (rx_idx == 3'd7) rx_state <= RX_STOP;
            else rx_idx <= rx_idx + 3'd1;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        RX_STOP: begin
          if (rx_cnt == LAST) begin
            rx_cnt <= '0;
            if (rx_s) begin
              rx_data  <= rx_shift;
              rx_valid <= 1'b1;
              rx_state <= RX_IDLE;
            end else begin
              rx_frame_err <= 1'b1;
              rx_state     <= RX_HOLD;
            end
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        RX_HOLD: if (rx_s) rx_state <= RX_IDLE;
        default: rx_state <= RX_IDLE;
      endcase
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_line);
  assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tx_line));
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |=> !rx_frame_err);
  assert_err_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_frame_err));
  assert_err_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> $stable(rx_data));
endmodule

// File: tb/test_msb_serial_link.sv
module test_msb_serial_link;
  localparam int CPB = 16;
  localparam int HALF = CPB / 2;

  logic clk = 0, rst_n = 0;
  logic [7:0] tx_data = 0;
  logic tx_send = 0, loop = 1, drv = 1;
  logic tx_busy, tx_line, rx_valid, rx_frame_err;
  logic [7:0] rx_data;
  logic rx_in;

  assign rx_in = loop ? tx_line : drv;

  msb_serial_link #(.CLKS_PER_BIT(CPB)) i_msb_serial_link (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_send(tx_send),
    .tx_busy(tx_busy), .tx_line(tx_line), .rx_line(rx_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err));

  always #10 clk = ~clk;

  int total = 0, bad = 0, n_valid = 0, n_err = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      n_valid++;
      if (exp_q.size() == 0) chk(0, "R5 unexpected byte", int'(rx_data), 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R5/R9 received byte", int'(rx_data), int'(e));
      end
    end
    if (rx_frame_err) n_err++;
  end

  task automatic send_byte(input logic [7:0] b, input bit poke);
    logic [9:0] exp;
    exp = {1'b0, b, 1'b1};
    @(negedge clk);
    tx_data = b; tx_send = 1;
    exp_q.push_back(b);
    @(negedge clk);
    tx_send = 0; tx_data = 8'h00;
    chk(tx_busy == 1, "R3 busy after strobe", int'(tx_busy), 1);
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      if (k > 0) begin
        if (poke && k == 4) begin
          tx_send = 1; tx_data = ~b;
          @(negedge clk);
          tx_send = 0;
          repeat (CPB - 1) @(negedge clk);
        end else repeat (CPB) @(negedge clk);
      end
      chk(tx_line == exp[9-k], poke ? "R4 frame kept" : "R2 frame bit", int'(tx_line), int'(exp[9-k]));
      chk(tx_busy == 1, "R3 busy during frame", int'(tx_busy), 1);
    end
    repeat (CPB - HALF) @(negedge clk);
    chk(tx_busy == 0, "R3 busy clear after stop", int'(tx_busy), 0);
    chk(tx_line == 1, "R3 line idle after stop", int'(tx_line), 1);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stopb);
    @(negedge clk);
    drv = 0;
    repeat (CPB) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      drv = b[i];
      repeat (CPB) @(negedge clk);
    end
    drv = stopb;
    repeat (CPB) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_line == 1, "R1 line idle", int'(tx_line), 1);
    chk(tx_busy == 0, "R1 busy low", int'(tx_busy), 0);
    chk(rx_valid == 0, "R1 valid low", int'(rx_valid), 0);
    chk(rx_frame_err == 0, "R1 err low", int'(rx_frame_err), 0);

    send_byte(8'h41, 0);
    send_byte(8'hA5, 1);
    send_byte(8'h00, 0);
    send_byte(8'hFF, 0);
    repeat (CPB) @(negedge clk);
    chk(tx_busy == 0, "R4 no extra frame", int'(tx_busy), 0);
    repeat (CPB) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all looped bytes seen", exp_q.size(), 0);
    chk(n_valid == 4, "R9 valid count", n_valid, 4);
    chk(n_err == 0, "R9 no errors", n_err, 0);

    loop = 0; drv = 1;
    repeat (2 * CPB) @(negedge clk);
    drv = 0;
    repeat (HALF / 2) @(negedge clk);
    drv = 1;
    repeat (12 * CPB) @(negedge clk);
    chk(n_valid == 4, "R6 glitch gives no byte", n_valid, 4);
    chk(n_err == 0, "R6 glitch gives no error", n_err, 0);

    exp_q.push_back(8'hC3);
    drive_frame(8'hC3, 1);
    drv = 1;
    repeat (2 * CPB) @(negedge clk);
    chk(n_valid == 5, "R5 direct frame", n_valid, 5);

    drive_frame(8'h5A, 0);
    repeat (3 * CPB) @(negedge clk);
    chk(n_err == 1, "R7 error pulse", n_err, 1);
    chk(n_valid == 5, "R7 no valid on error", n_valid, 5);
    chk(rx_data == 8'hC3, "R7 data kept", int'(rx_data), 8'hC3);
    drv = 1;
    repeat (2 * CPB) @(negedge clk);
    chk(n_err == 1, "R8 single error for held low", n_err, 1);
    exp_q.push_back(8'h3C);
    drive_frame(8'h3C, 1);
    drv = 1;
    repeat (2 * CPB) @(negedge clk);
    chk(n_valid == 6, "R8 recovery frame", n_valid, 6);
    chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule